// File: doc/BRIEF.md
# Block-matching SAD engine with threshold abort

This engine measures how well one candidate reference block matches the current block in a motion search. Each input beat carries eight current pixels and the eight reference pixels at the same positions, packed as two 64-bit words. For every beat the engine takes the absolute difference of each byte pair, adds the eight results in the same cycle, and adds that beat total to a 16-bit running cost. A 16x16 block arrives as 32 beats: 16 rows, two beats per row.

A start pulse opens a new candidate. It clears the running cost and captures a cost limit and a limit-enable bit. While the limit is enabled, the running cost is compared with the limit after every beat. As soon as the cost is equal to or above the limit, the candidate is abandoned. The engine then flags it as rejected and finished, and any beats that arrive for the rest of that block are dropped. Without an abort, the candidate finishes after its 32nd beat and the full cost is shown.

The pixel input is a valid/ready stream. A beat is taken on a rising clock edge when `pix_valid` and `pix_ready` are both high. `pix_ready` is low only in a cycle where `start` is high, so a beat offered together with a start pulse is held back, not consumed. At all other times the engine takes every offered beat. Beats taken while no candidate is running are thrown away. The source may drop `pix_valid` between beats for any number of cycles.

Top module: `sad_block_matcher`

## Requirements
- R1: Byte lane k of a word occupies bits [8k+7:8k]. Each taken beat of a running candidate adds the sum over the eight lanes of |cur − ref| to the running cost `cost`, in the clock edge that takes the beat.
- R2: `cost` is 16 bits wide and does not wrap. A block of 32 beats with every current byte 0xFF and every reference byte 0x00 ends with `cost` = 65280.
- R3: After a `start` pulse, `cost` is 0, `finished` and `rejected` are low and `running` is high. `limit` and `limit_en` are captured in that same edge.
- R4: With the limit enabled, the edge that takes a beat making the running cost ≥ the captured limit sets `finished` and `rejected`, and `cost` holds that total. Equality counts as reaching the limit, and a limit of 0 rejects on the first beat.
- R5: If the candidate is not rejected, the edge that takes its 32nd beat sets `finished`, and `rejected` stays low.
- R6: Beats taken while no candidate is running (after reset, after finish, or after rejection) leave `cost`, `finished` and `rejected` unchanged.
- R7: With the limit disabled, `rejected` never rises, whatever the limit value.
- R8: `pix_ready` is low exactly in cycles where `start` is high. Cycles with `pix_valid` low, or with `pix_ready` low, add nothing and do not count as beats.
- R9: A `start` pulse while a candidate is running discards it. The next candidate counts its own 32 beats from zero.
- R10: After reset `cost` is 0 and `finished`, `rejected` and `running` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new candidate; captures limit and limit_en |
| limit | input | 16 | Cost limit used for early abort |
| limit_en | input | 1 | Enables the early abort |
| pix_valid | input | 1 | A beat is offered |
| pix_ready | output | 1 | Engine can take the offered beat |
| cur_pix | input | 64 | Eight current-block pixels |
| ref_pix | input | 64 | Eight reference-block pixels |
| cost | output | 16 | Running, then final, SAD of the candidate |
| finished | output | 1 | Candidate ended (full block or abort) |
| rejected | output | 1 | Candidate ended by the limit |
| running | output | 1 | A candidate is accepting beats |

## Verification
The bench builds the engine with its default parameters: eight 8-bit lanes, a 16-bit cost and 32 beats per block. With these values, a block of all-maximum differences lands at 65280, just below the wrap point of the cost register. Limits of 0, an exact beat-boundary total and a total passed mid-block can all be reached with short, hand-computed pixel patterns. Behind these directed cases runs a behavioural model that tracks the cost, the beat count and the abort on every clock. That model also checks the limit-disabled, gapped-valid, start-collision and restart sequences.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [1:0] {
    MT_IDLE = 2'd0,
    MT_RUN  = 2'd1,
    MT_END  = 2'd2
  } match_state_e;
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] a_pix,
  input  logic [PIX_W-1:0] b_pix,
  output logic [PIX_W-1:0] diff
);
  always_comb begin
    if (a_pix >= b_pix) diff = a_pix - b_pix;
    else                diff = b_pix - a_pix;
  end
endmodule

// File: rtl/sad_lane_sum.sv
module sad_lane_sum #(
  parameter int LANES = 8,
  parameter int PIX_W = 8,
  parameter int SUM_W = PIX_W + $clog2(LANES)
) (
  input  logic [LANES*PIX_W-1:0] cur_word,
  input  logic [LANES*PIX_W-1:0] ref_word,
  output logic [SUM_W-1:0]       beat_sum
);
  localparam int MAX_SUM = LANES * ((1 << PIX_W) - 1);

  logic [PIX_W-1:0] lane_d [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sad_absdiff #(.PIX_W(PIX_W)) u_ad (
      .a_pix(cur_word[k*PIX_W +: PIX_W]),
      .b_pix(ref_word[k*PIX_W +: PIX_W]),
      .diff (lane_d[k])
    );
  end

  always_comb begin
    beat_sum = '0;
    for (int k = 0; k < LANES; k++) begin
      beat_sum = beat_sum + SUM_W'(lane_d[k]);
    end
  end

  // R1: the horizontal sum never exceeds eight full-scale differences
  always_comb begin
    assert_sum_range_R1: assert (32'(beat_sum) <= MAX_SUM);
  end
endmodule

// File: rtl/sad_accum_ctrl.sv
module sad_accum_ctrl
  import sad_pkg::*;
#(
  parameter int SUM_W = 11,
  parameter int ACC_W = 16,
  parameter int BEATS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ACC_W-1:0] limit,
  input  logic             limit_en,
  input  logic             beat_fire,
  input  logic [SUM_W-1:0] beat_sum,
  output logic [ACC_W-1:0] cost,
  output logic             finished,
  output logic             rejected,
  output logic             running
);
  localparam int CNT_W = $clog2(BEATS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

  match_state_e     state_q;
  logic [ACC_W-1:0] acc_q, acc_next;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] lim_q;
  logic             lim_en_q;
  logic             rej_q;
  logic             take, hit, last;

  assign take     = beat_fire && (state_q == MT_RUN);
  assign acc_next = acc_q + ACC_W'(beat_sum);
  assign hit      = lim_en_q && (acc_next >= lim_q);
  assign last     = (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= MT_IDLE;
      acc_q    <= '0;
      cnt_q    <= '0;
      lim_q    <= '0;
      lim_en_q <= 1'b0;
      rej_q    <= 1'b0;
    end else if (start) begin
      state_q  <= MT_RUN;
      acc_q    <= '0;
      cnt_q    <= '0;
      lim_q    <= limit;
      lim_en_q <= limit_en;
      rej_q    <= 1'b0;
    end else if (take) begin
      acc_q <= acc_next;
      cnt_q <= cnt_q + 1'b1;
      if (hit) begin
        state_q <= MT_END;
        rej_q   <= 1'b1;
      end else if (last) begin
        state_q <= MT_END;
      end
    end
  end

  assign cost     = acc_q;
  assign finished = (state_q == MT_END);
  assign rejected = rej_q;
  assign running  = (state_q == MT_RUN);

  assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cost == '0 && !finished && !rejected && running));

  assert_reject_has_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> finished);

  assert_full_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !rejected) |-> (cnt_q == CNT_W'(BEATS)));

  assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> ($stable(cost) && $stable(rejected)));

  assert_no_reject_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !lim_en_q && !start) |=> !rejected);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |=> (cost >= $past(cost)));
endmodule

// File: rtl/sad_block_matcher.sv
module sad_block_matcher #(
  parameter int LANES    = 8,
  parameter int PIX_W    = 8,
  parameter int ACC_W    = 16,
  parameter int ROWS     = 16,
  parameter int ROW_BEAT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ACC_W-1:0]       limit,
  input  logic                   limit_en,
  input  logic                   pix_valid,
  output logic                   pix_ready,
  input  logic [LANES*PIX_W-1:0] cur_pix,
  input  logic [LANES*PIX_W-1:0] ref_pix,
  output logic [ACC_W-1:0]       cost,
  output logic                   finished,
  output logic                   rejected,
  output logic                   running
);
  localparam int BEATS = ROWS * ROW_BEAT;
  localparam int SUM_W = PIX_W + $clog2(LANES);

  logic [SUM_W-1:0] beat_sum;
  logic             beat_fire;

  assign pix_ready = !start;
  assign beat_fire = pix_valid && pix_ready;

  sad_lane_sum #(.LANES(LANES), .PIX_W(PIX_W), .SUM_W(SUM_W)) u_sum (
    .cur_word(cur_pix),
    .ref_word(ref_pix),
    .beat_sum(beat_sum)
  );

  sad_accum_ctrl #(.SUM_W(SUM_W), .ACC_W(ACC_W), .BEATS(BEATS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .limit    (limit),
    .limit_en (limit_en),
    .beat_fire(beat_fire),
    .beat_sum (beat_sum),
    .cost     (cost),
    .finished (finished),
    .rejected (rejected),
    .running  (running)
  );

  // R8: a beat offered with start is not taken, so the cost cannot move
  assert_start_blocks_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pix_valid) |=> (cost == '0));
endmodule

// File: tb/sad_block_matcher_test.sv
module sad_block_matcher_test;
  localparam int PERIOD = 10;
  localparam int NBEATS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] limit = '0;
  logic        limit_en = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [63:0] cur_pix = '0;
  logic [63:0] ref_pix = '0;
  logic [15:0] cost;
  logic        finished, rejected, running;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  // behavioural reference state
  int m_acc = 0, m_cnt = 0, m_lim = 0, m_state = 0;
  bit m_en = 0, m_rej = 0;

  sad_block_matcher uut (
    .clk(clk), .rst_n(rst_n), .start(start), .limit(limit), .limit_en(limit_en),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .cur_pix(cur_pix), .ref_pix(ref_pix),
    .cost(cost), .finished(finished), .rejected(rejected), .running(running)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int word_sad(logic [63:0] a, logic [63:0] b);
    int s = 0;
    for (int k = 0; k < 8; k++) begin
      int x = int'(a[8*k +: 8]);
      int y = int'(b[8*k +: 8]);
      s += (x > y) ? x - y : y - x;
    end
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, state 0 idle, 1 running, 2 finished
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_lim = 0; m_en = 0; m_rej = 0; m_state = 0;
    end else if (start) begin
      m_acc = 0; m_cnt = 0; m_lim = int'(limit); m_en = limit_en; m_rej = 0; m_state = 1;
    end else if (pix_valid && m_state == 1) begin
      m_acc += word_sad(cur_pix, ref_pix);
      m_cnt++;
      if (m_en && m_acc >= m_lim) begin
        m_rej = 1; m_state = 2;
      end else if (m_cnt == NBEATS) begin
        m_state = 2;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      check("R1 model cost", int'(cost), m_acc);
      check("R5 model finished", int'(finished), int'(m_state == 2));
      check("R4 model rejected", int'(rejected), int'(m_rej));
      check("R3 model running", int'(running), int'(m_state == 1));
      check("R8 model ready", int'(pix_ready), int'(!start));
    end
  end

  task automatic begin_block(int lim, bit en);
    start = 1'b1; limit = 16'(lim); limit_en = en;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic send(logic [63:0] c, logic [63:0] r);
    pix_valid = 1'b1; cur_pix = c; ref_pix = r;
    @(posedge clk); #1;
    pix_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp;
    logic [63:0] c, r;
    idle(3);
    // R10 reset state
    check("R10 reset cost", int'(cost), 0);
    check("R10 reset finished", int'(finished), 0);
    check("R10 reset rejected", int'(rejected), 0);
    check("R10 reset running", int'(running), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(1);

    // R6 beats before any start are dropped
    send({8{8'hFF}}, '0);
    send({8{8'h10}}, '0);
    check("R6 idle beats cost", int'(cost), 0);
    check("R6 idle beats finished", int'(finished), 0);

    // R1/R5 full random block, limit disabled
    begin_block(0, 1'b0);
    check("R3 start clears", int'(cost), 0);
    check("R3 running", int'(running), 1);
    exp = 0;
    for (int i = 0; i < NBEATS; i++) begin
      c = {$urandom, $urandom}; r = {$urandom, $urandom};
      exp += word_sad(c, r);
      send(c, r);
    end
    check("R1 random block cost", int'(cost), exp);
    check("R5 finished after 32", int'(finished), 1);
    check("R5 not rejected", int'(rejected), 0);

    // R2 maximum block
    begin_block(0, 1'b0);
    for (int i = 0; i < NBEATS; i++) send({8{8'hFF}}, '0);
    check("R2 max cost", int'(cost), 65280);
    check("R2 finished", int'(finished), 1);

    // R4 abort past limit, then R6 drop later beats
    begin_block(1000, 1'b1);
    send({8{8'd150}}, {8{8'd50}});
    check("R4 below limit not finished", int'(finished), 0);
    send({8{8'd50}}, {8{8'd150}});
    check("R4 abort cost", int'(cost), 1600);
    check("R4 rejected", int'(rejected), 1);
    check("R4 finished", int'(finished), 1);
    send({8{8'hFF}}, '0);
    send({8{8'hFF}}, '0);
    check("R6 after abort cost", int'(cost), 1600);
    check("R6 after abort rejected", int'(rejected), 1);

    // R4 equality rejects
    begin_block(1600, 1'b1);
    send({8{8'd100}}, '0);
    check("R4 eq not yet", int'(rejected), 0);
    send({8{8'd100}}, '0);
    check("R4 eq rejected", int'(rejected), 1);
    check("R4 eq cost", int'(cost), 1600);

    // R4 limit zero rejects at first beat
    begin_block(0, 1'b1);
    send('0, '0);
    check("R4 zero limit rejected", int'(rejected), 1);
    check("R4 zero limit cost", int'(cost), 0);

    // R7 disabled limit with tiny value, R8 gaps between beats
    begin_block(1, 1'b0);
    for (int i = 0; i < NBEATS; i++) begin
      send({8{8'd100}}, '0);
      if (i % 3 == 0) idle(2);
    end
    check("R7 disabled not rejected", int'(rejected), 0);
    check("R7 disabled cost", int'(cost), 25600);
    check("R8 gaps finished", int'(finished), 1);

    // R8 beat offered with start is not taken
    pix_valid = 1'b1; cur_pix = {8{8'hFF}}; ref_pix = '0;
    start = 1'b1; limit = '0; limit_en = 1'b0;
    #1;
    check("R8 ready low with start", int'(pix_ready), 0);
    @(posedge clk); #1;
    start = 1'b0; pix_valid = 1'b0;
    check("R8 collided beat dropped", int'(cost), 0);

    // R9 restart mid-run
    for (int i = 0; i < 5; i++) send({8{8'd9}}, '0);
    check("R9 partial cost", int'(cost), 360);
    begin_block(0, 1'b0);
    check("R9 restart clears", int'(cost), 0);
    for (int i = 0; i < NBEATS - 1; i++) send({8{8'd1}}, '0);
    check("R9 not finished at 31", int'(finished), 0);
    send({8{8'd1}}, '0);
    check("R9 finished at 32", int'(finished), 1);
    check("R9 cost", int'(cost), 256);

    idle(3);
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule